// File: doc/BRIEF.md
# Three-Stage Batched Memory Request Scheduler

The block sits between a set of request sources (processor cores, an accelerator) and the banks of a memory device. Requests arrive over one valid/ready port tagged with a source number, a bank and a row. They move through three stages, each built only from in-order FIFOs. The first stage keeps one queue per source and groups the run of equal-address requests at each queue head into a batch. The second stage picks one source's finished batch at a time and moves it whole into the per-bank queues. The third stage keeps one queue per bank and presents each bank's oldest request on its own valid/ready issue port. The bank's controller holds issue ready low while the bank is busy.

The batch picker decides each time between two policies. Shortest-queue-first favours lightly loaded (latency-sensitive) sources. Rotating priority gives every source its turn, which suits heavy streaming sources. An 8-bit pseudo-random value is compared with a programmable level, so software sets the share of decisions that use shortest-queue-first. Nothing is reordered after the second stage. A full bank queue therefore stalls the whole transfer path and does not let other traffic slip past.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` depends on `req_src`, so the requester holds valid and all request fields stable until the request is taken. An issue port hands over its request on an edge where `issue_valid` and `issue_ready` of that bank are both high. While a port waits, its data does not change.

Top module: `batch_mem_sched`

## Requirements
- R1: A request is accepted exactly when `req_valid` and `req_ready` are high at a clock edge. `req_ready` is low exactly when the queue of the source named on `req_src` already holds 8 entries.
- R2: A batch is the run of consecutive requests at the head of one source queue that have equal bank and equal row. The batch becomes eligible as soon as a later request of that source with a different bank or row is queued behind it.
- R3: A batch holds at most 4 requests. A run of 4 equal requests becomes eligible at once, and any further equal requests form a new batch.
- R4: A batch with no other closing condition becomes eligible once its head request has been at the queue head for 64 cycles, and not before.
- R5: For each batch decision, an 8-bit pseudo-random value (never zero) is compared with `sjf_prob`. Shortest-queue-first is used when the value is less than or equal to `sjf_prob`, otherwise rotating priority. So 255 always selects shortest-queue-first and 0 never does.
- R6: Shortest-queue-first grants the eligible source with the fewest requests held in its first-stage queue. Ties go to the lowest source number.
- R7: Rotating priority grants the first eligible source after the most recently granted source, in increasing source number, wrapping around.
- R8: A granted batch moves into its bank queue at one request per cycle, completely, before any other batch starts. If that bank queue (4 entries) is full, the move stalls and no request of any other source reaches any bank queue.
- R9: Each bank port presents its oldest queued request. For each source and bank pair, requests are issued in acceptance order, and every accepted request is issued exactly once.
- R10: After reset every queue is empty: `req_ready` is high and every `issue_valid` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sjf_prob | input | 8 | Level for choosing shortest-queue-first over rotating priority |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Addressed source queue can take the request |
| req_src | input | 2 | Source number of the request |
| req_bank | input | 2 | Target bank |
| req_row | input | 8 | Target row |
| issue_ready | input | 4 | Per bank: bank can take a request (low while busy) |
| issue_valid | output | 4 | Per bank: a request is waiting |
| issue_src | output | 8 | Per bank, 2 bits each (bank b at bits 2b+1:2b): source of the waiting request |
| issue_row | output | 32 | Per bank, 8 bits each (bank b at bits 8b+7:8b): row of the waiting request |

## Verification
The interesting overlap is a batch decision that has two competing candidates while an earlier batch is frozen by a full bank queue. The bench holds bank 0 busy so that one source's second batch stalls. Behind it, it queues a four-request source and a two-request source for bank 1, then releases bank 0. The first request that appears on bank 1 tells which policy won: the short source when the level is 255, and the source next in rotation when it is 0. Bank 1 must stay silent while the stall lasts. Throughout the random phase, every issue is matched against per-source, per-bank expected queues.

// File: rtl/bms_pkg.sv
package bms_pkg;

  typedef enum logic [0:0] {
    ARB_IDLE = 1'b0,
    ARB_XFER = 1'b1
  } arb_state_e;

  // x^8 + x^6 + x^5 + x^4 + 1, maximal length, never reaches zero from a non-zero seed
  function automatic logic [7:0] lfsr8_step(input logic [7:0] v);
    return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
  endfunction

  function automatic int ring_add(input int p, input int k, input int depth);
    int t;
    t = p + k;
    if (t >= depth) t = t - depth;
    return t;
  endfunction

endpackage

// File: rtl/bms_src_queue.sv
module bms_src_queue
  import bms_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int ROW_W     = 8,
  parameter int BANK_W    = 2,
  parameter int BATCH_MAX = 4,
  parameter int AGE_LIMIT = 64,
  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int LEN_W    = $clog2(BATCH_MAX + 1),
  localparam int AGE_W    = $clog2(AGE_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [BANK_W-1:0] push_bank,
  input  logic [ROW_W-1:0]  push_row,
  output logic              full,
  input  logic              pop,
  output logic [CNT_W-1:0]  count,
  output logic              batch_ready,
  output logic [LEN_W-1:0]  batch_len,
  output logic [BANK_W-1:0] head_bank,
  output logic [ROW_W-1:0]  head_row
);

  logic [BANK_W-1:0] bank_mem [DEPTH];
  logic [ROW_W-1:0]  row_mem  [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [CNT_W-1:0]  cnt;
  logic [AGE_W-1:0]  age;
  logic [LEN_W-1:0]  run;
  logic              run_open;
  logic [PTR_W-1:0]  peek;
  logic              age_hit;

  assign full      = (cnt == CNT_W'(DEPTH));
  assign count     = cnt;
  assign head_bank = bank_mem[rd_ptr];
  assign head_row  = row_mem[rd_ptr];
  assign age_hit   = (age == AGE_W'(AGE_LIMIT));

  always_ff @(posedge clk) begin
    if (push) begin
      bank_mem[wr_ptr] <= push_bank;
      row_mem[wr_ptr]  <= push_row;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(ring_add(int'(wr_ptr), 1, DEPTH));
      if (pop)  rd_ptr <= PTR_W'(ring_add(int'(rd_ptr), 1, DEPTH));
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // waiting time of the current head entry, restarts whenever the head changes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age <= '0;
    end else if (cnt == '0 || pop) begin
      age <= '0;
    end else if (!age_hit) begin
      age <= age + 1'b1;
    end
  end

  // length of the equal-address run at the head, capped at BATCH_MAX
  always_comb begin
    run      = '0;
    run_open = 1'b1;
    peek     = rd_ptr;
    for (int k = 0; k < BATCH_MAX; k++) begin
      peek = PTR_W'(ring_add(int'(rd_ptr), k, DEPTH));
      if (run_open && (k < int'(cnt)) &&
          (bank_mem[peek] == bank_mem[rd_ptr]) && (row_mem[peek] == row_mem[rd_ptr])) begin
        run = LEN_W'(k + 1);
      end else begin
        run_open = 1'b0;
      end
    end
  end

  assign batch_len   = run;
  assign batch_ready = (cnt != '0) &&
                       ((run == LEN_W'(BATCH_MAX)) || (int'(cnt) > int'(run)) || age_hit);

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (cnt == $past(cnt) + 1'b1))
    else $error("source queue count did not follow an accepted request");

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0))
    else $error("source queue popped while empty");

endmodule

// File: rtl/bms_batch_arb.sv
module bms_batch_arb
  import bms_pkg::*;
#(
  parameter int NSRC   = 4,
  parameter int NBANK  = 4,
  parameter int BANK_W = 2,
  parameter int CNT_W  = 4,
  parameter int LEN_W  = 3,
  localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              sjf_prob,
  input  logic [NSRC-1:0]         src_ready,
  input  logic [NSRC*CNT_W-1:0]   src_cnt,
  input  logic [NSRC*LEN_W-1:0]   src_len,
  input  logic [NSRC*BANK_W-1:0]  src_bank,
  input  logic [NBANK-1:0]        bank_full,
  output logic [NSRC-1:0]         src_pop,
  output logic [NBANK-1:0]        bank_push,
  output logic [SRC_W-1:0]        cur_src
);

  arb_state_e        state_q;
  logic [SRC_W-1:0]  sel_q, rr_last_q;
  logic [LEN_W-1:0]  remain_q;
  logic [7:0]        lfsr_q;

  logic              use_sjf, any_ready, sjf_found, rr_found;
  logic [SRC_W-1:0]  sjf_pick, rr_pick, pick;
  logic [CNT_W-1:0]  best_cnt;
  logic [BANK_W-1:0] head_bank;
  logic              move;

  assign use_sjf   = (lfsr_q <= sjf_prob);
  assign any_ready = |src_ready;

  always_comb begin
    sjf_found = 1'b0;
    sjf_pick  = '0;
    best_cnt  = '1;
    for (int s = 0; s < NSRC; s++) begin
      if (src_ready[s] && (!sjf_found || (src_cnt[s*CNT_W +: CNT_W] < best_cnt))) begin
        sjf_found = 1'b1;
        best_cnt  = src_cnt[s*CNT_W +: CNT_W];
        sjf_pick  = SRC_W'(s);
      end
    end
  end

  always_comb begin
    rr_found = 1'b0;
    rr_pick  = '0;
    for (int off = 1; off <= NSRC; off++) begin
      int idx;
      idx = (int'(rr_last_q) + off) % NSRC;
      if (!rr_found && src_ready[idx]) begin
        rr_found = 1'b1;
        rr_pick  = SRC_W'(idx);
      end
    end
  end

  assign pick      = use_sjf ? sjf_pick : rr_pick;
  assign head_bank = src_bank[sel_q*BANK_W +: BANK_W];
  assign move      = (state_q == ARB_XFER) && !bank_full[head_bank];
  assign cur_src   = sel_q;

  always_comb begin
    src_pop   = '0;
    bank_push = '0;
    if (move) begin
      src_pop[sel_q]       = 1'b1;
      bank_push[head_bank] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ARB_IDLE;
      sel_q     <= '0;
      rr_last_q <= SRC_W'(NSRC - 1);
      remain_q  <= '0;
      lfsr_q    <= 8'h01;
    end else begin
      case (state_q)
        ARB_IDLE: begin
          if (any_ready) begin
            sel_q     <= pick;
            rr_last_q <= pick;
            remain_q  <= src_len[pick*LEN_W +: LEN_W];
            lfsr_q    <= lfsr8_step(lfsr_q);
            state_q   <= ARB_XFER;
          end
        end
        default: begin
          if (move) begin
            remain_q <= remain_q - 1'b1;
            if (remain_q == LEN_W'(1)) state_q <= ARB_IDLE;
          end
        end
      endcase
    end
  end

  assert_batch_atomic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARB_XFER) |=> (state_q == ARB_IDLE) || (sel_q == $past(sel_q)))
    else $error("batch source changed during a transfer");

  assert_lfsr_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 8'h00)
    else $error("policy generator reached the all-zero state");

  assert_grant_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARB_IDLE && any_ready) |-> src_ready[pick])
    else $error("grant chose a source without an eligible batch");

endmodule

// File: rtl/bms_bank_queue.sv
module bms_bank_queue
  import bms_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int DW      = 10,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          full,
  output logic          issue_valid,
  input  logic          issue_ready,
  output logic [DW-1:0] issue_data
);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] cnt;
  logic             take;

  assign full        = (cnt == CNT_W'(DEPTH));
  assign issue_valid = (cnt != '0);
  assign issue_data  = mem[rd_ptr];
  assign take        = issue_valid && issue_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(ring_add(int'(wr_ptr), 1, DEPTH));
      if (take) rd_ptr <= PTR_W'(ring_add(int'(rd_ptr), 1, DEPTH));
      case ({push, take})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full))
    else $error("bank queue written while full");

  assert_issue_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_ready) |=> (issue_valid && $stable(issue_data)))
    else $error("waiting issue request changed or vanished");

endmodule

// File: rtl/batch_mem_sched.sv
module batch_mem_sched
  import bms_pkg::*;
#(
  parameter int NSRC       = 4,
  parameter int NBANK      = 4,
  parameter int ROW_W      = 8,
  parameter int SRC_DEPTH  = 8,
  parameter int BANK_DEPTH = 4,
  parameter int BATCH_MAX  = 4,
  parameter int AGE_LIMIT  = 64,
  localparam int SRC_W     = $clog2(NSRC),
  localparam int BANK_W    = $clog2(NBANK),
  localparam int CNT_W     = $clog2(SRC_DEPTH + 1),
  localparam int LEN_W     = $clog2(BATCH_MAX + 1),
  localparam int ENTRY_W   = SRC_W + ROW_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              sjf_prob,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [SRC_W-1:0]        req_src,
  input  logic [BANK_W-1:0]       req_bank,
  input  logic [ROW_W-1:0]        req_row,
  input  logic [NBANK-1:0]        issue_ready,
  output logic [NBANK-1:0]        issue_valid,
  output logic [NBANK*SRC_W-1:0]  issue_src,
  output logic [NBANK*ROW_W-1:0]  issue_row
);

  logic [NSRC-1:0]        src_full, src_ready, src_pop;
  logic [NSRC*CNT_W-1:0]  src_cnt;
  logic [NSRC*LEN_W-1:0]  src_len;
  logic [NSRC*BANK_W-1:0] src_bank;
  logic [NSRC*ROW_W-1:0]  src_row;
  logic [NBANK-1:0]       bank_full, bank_push;
  logic [SRC_W-1:0]       cur_src;
  logic [ENTRY_W-1:0]     move_data;

  assign req_ready = !src_full[req_src];

  // stage 1: one queue per source, batch detection at each head
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    bms_src_queue #(
      .DEPTH(SRC_DEPTH), .ROW_W(ROW_W), .BANK_W(BANK_W),
      .BATCH_MAX(BATCH_MAX), .AGE_LIMIT(AGE_LIMIT)
    ) u_srcq (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (req_valid && req_ready && (req_src == SRC_W'(s))),
      .push_bank  (req_bank),
      .push_row   (req_row),
      .full       (src_full[s]),
      .pop        (src_pop[s]),
      .count      (src_cnt[s*CNT_W +: CNT_W]),
      .batch_ready(src_ready[s]),
      .batch_len  (src_len[s*LEN_W +: LEN_W]),
      .head_bank  (src_bank[s*BANK_W +: BANK_W]),
      .head_row   (src_row[s*ROW_W +: ROW_W])
    );
  end

  // stage 2: whole-batch selection and transfer
  bms_batch_arb #(
    .NSRC(NSRC), .NBANK(NBANK), .BANK_W(BANK_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .sjf_prob (sjf_prob),
    .src_ready(src_ready),
    .src_cnt  (src_cnt),
    .src_len  (src_len),
    .src_bank (src_bank),
    .bank_full(bank_full),
    .src_pop  (src_pop),
    .bank_push(bank_push),
    .cur_src  (cur_src)
  );

  assign move_data = {cur_src, src_row[cur_src*ROW_W +: ROW_W]};

  // stage 3: one in-order queue per bank
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [ENTRY_W-1:0] head;
    bms_bank_queue #(.DEPTH(BANK_DEPTH), .DW(ENTRY_W)) u_bankq (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (bank_push[b]),
      .push_data  (move_data),
      .full       (bank_full[b]),
      .issue_valid(issue_valid[b]),
      .issue_ready(issue_ready[b]),
      .issue_data (head)
    );
    assign issue_src[b*SRC_W +: SRC_W] = head[ENTRY_W-1 -: SRC_W];
    assign issue_row[b*ROW_W +: ROW_W] = head[ROW_W-1:0];
  end

  assert_single_mover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_pop) && ($countones(src_pop) == $countones(bank_push)))
    else $error("transfer moved requests of more than one source");

endmodule

// File: tb/batch_mem_sched_bench.sv
`timescale 1ns/1ps
module batch_mem_sched_bench;
  localparam int NSRC = 4, NBANK = 4, ROW_W = 8, SLOTS = 256, LOGN = 512;

  logic             clk = 1'b0, rst_n = 1'b0;
  logic [7:0]       sjf_prob = 8'd255;
  logic             req_valid = 1'b0, req_ready;
  logic [1:0]       req_src = '0, req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [NBANK-1:0] issue_ready = '0, issue_valid;
  logic [NBANK*2-1:0]     issue_src;
  logic [NBANK*ROW_W-1:0] issue_row;

  batch_mem_sched u_batch_mem_sched (
    .clk(clk), .rst_n(rst_n), .sjf_prob(sjf_prob),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .req_bank(req_bank), .req_row(req_row),
    .issue_ready(issue_ready), .issue_valid(issue_valid),
    .issue_src(issue_src), .issue_row(issue_row)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, total_acc = 0, total_iss = 0;
  int exp_row [NSRC][NBANK][SLOTS];
  int exp_wr  [NSRC][NBANK];
  int exp_rd  [NSRC][NBANK];
  int log_src [NBANK][LOGN];
  int log_row [NBANK][LOGN];
  int log_cnt [NBANK];
  bit rand_ready = 1'b0, done = 1'b0;
  logic [NBANK-1:0] ready_cfg = '1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // bank ready driver: one place changes issue_ready, just after the rising edge
  always @(posedge clk) begin
    #1;
    if (rand_ready) begin
      for (int b = 0; b < NBANK; b++) issue_ready[b] = ($urandom_range(0, 3) != 0);
    end else begin
      issue_ready = ready_cfg;
    end
  end

  // issue monitor: a request leaves on the next rising edge when valid and ready
  always @(negedge clk) begin
    if (rst_n) begin
      for (int b = 0; b < NBANK; b++) begin
        if (issue_valid[b] && issue_ready[b]) begin
          int s, r;
          s = int'(issue_src[b*2 +: 2]);
          r = int'(issue_row[b*ROW_W +: ROW_W]);
          if (exp_rd[s][b] < exp_wr[s][b]) begin
            check(r == exp_row[s][b][exp_rd[s][b] % SLOTS], "R9", "issue order per source and bank",
                  r, exp_row[s][b][exp_rd[s][b] % SLOTS]);
            exp_rd[s][b]++;
          end else begin
            check(1'b0, "R9", "issue without accepted request", r, -1);
          end
          if (log_cnt[b] < LOGN) begin
            log_src[b][log_cnt[b]] = s;
            log_row[b][log_cnt[b]] = r;
          end
          log_cnt[b]++;
          total_iss++;
        end
      end
    end
  end

  task automatic push_req(input int s, input int b, input int r);
    @(negedge clk);
    req_valid = 1'b1;
    req_src   = 2'(s);
    req_bank  = 2'(b);
    req_row   = ROW_W'(r);
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    exp_row[s][b][exp_wr[s][b] % SLOTS] = r;
    exp_wr[s][b]++;
    total_acc++;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wait_drain(input string tag);
    int n;
    ready_cfg = '1;
    n = 0;
    while (total_iss != total_acc && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(total_iss == total_acc, "R9", {"every accepted request issued once after ", tag},
          total_iss, total_acc);
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // policy contest behind a stalled batch; prob selects the policy, expected winner given
  task automatic contest(input logic [7:0] prob, input int exp_src, input int exp_r, input string req);
    int base;
    sjf_prob  = prob;
    ready_cfg = 4'b1110;
    wait_neg(3);
    base = log_cnt[1];
    for (int i = 0; i < 4; i++) push_req(3, 0, 10);
    for (int i = 0; i < 4; i++) push_req(3, 0, 11);
    for (int i = 0; i < 3; i++) push_req(1, 1, 20);
    push_req(1, 1, 21);
    push_req(2, 1, 30);
    push_req(2, 1, 31);
    wait_neg(6);
    check(log_cnt[1] == base, "R8", "no bank-1 traffic passes a stalled transfer", log_cnt[1] - base, 0);
    ready_cfg = 4'b1111;
    wait_neg(20);
    check(log_cnt[1] > base, "R8", "bank 1 served after release", log_cnt[1] - base, 1);
    check(log_src[1][base] == exp_src, req, "first source on bank 1", log_src[1][base], exp_src);
    check(log_row[1][base] == exp_r, req, "first row on bank 1", log_row[1][base], exp_r);
    wait_drain(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int base;
    void'($urandom(32'd1234));
    for (int s = 0; s < NSRC; s++)
      for (int b = 0; b < NBANK; b++) begin
        exp_wr[s][b] = 0;
        exp_rd[s][b] = 0;
      end
    for (int b = 0; b < NBANK; b++) log_cnt[b] = 0;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "req_ready after reset", int'(req_ready), 1);
    check(issue_valid == '0, "R10", "issue_valid after reset", int'(issue_valid), 0);

    // R2: a row change behind the run closes a two-entry batch
    base = log_cnt[3];
    push_req(1, 3, 5);
    push_req(1, 3, 5);
    push_req(1, 3, 6);
    wait_neg(12);
    check(log_cnt[3] - base == 2, "R2", "batch closed by row change", log_cnt[3] - base, 2);
    check(log_row[3][base + 1] == 5, "R2", "batch row", log_row[3][base + 1], 5);
    wait_drain("R2");
    check(log_cnt[3] - base == 3, "R2", "trailing request issued", log_cnt[3] - base, 3);

    // R3 and R4: cap of four, remainder waits for the age limit
    base = log_cnt[2];
    for (int i = 0; i < 6; i++) push_req(0, 2, 9);
    wait_neg(20);
    check(log_cnt[2] - base == 4, "R3", "batch capped at four", log_cnt[2] - base, 4);
    wait_neg(30);
    check(log_cnt[2] - base == 4, "R4", "remainder held before age limit", log_cnt[2] - base, 4);
    wait_neg(40);
    check(log_cnt[2] - base == 6, "R4", "remainder released by age limit", log_cnt[2] - base, 6);

    // R1: source queue full drops ready for that source only
    ready_cfg = '0;
    wait_neg(3);
    for (int i = 0; i < 8; i++) push_req(3, 0, 1);
    for (int i = 2; i < 6; i++) push_req(3, 0, i);
    @(negedge clk);
    req_valid = 1'b1;
    req_src   = 2'd3;
    #1 check(req_ready == 1'b0, "R1", "ready low for full source", int'(req_ready), 0);
    req_src = 2'd0;
    #1 check(req_ready == 1'b1, "R1", "ready high for other source", int'(req_ready), 1);
    #1 req_valid = 1'b0;
    wait_drain("R1");

    // R5 with R6 and R7: same contest under each fixed policy
    contest(8'd255, 2, 30, "R6");
    contest(8'd0, 1, 20, "R7");

    // random traffic with runs, random bank back-pressure, mixed policy level
    rand_ready = 1'b1;
    begin
      int s, b, r;
      s = 0; b = 0; r = 0;
      for (int i = 0; i < 200; i++) begin
        if (i == 70)  sjf_prob = 8'd128;
        if (i == 140) sjf_prob = 8'd30;
        if ($urandom_range(0, 1) == 0) begin
          s = $urandom_range(0, 3);
          b = $urandom_range(0, 3);
          r = $urandom_range(0, 2);
        end
        push_req(s, b, r);
      end
    end
    rand_ready = 1'b0;
    wait_drain("R5 random mix");
    summary();
  end

endmodule